// File: doc/BRIEF.md
# Pin Pattern Match Engine

The engine watches a wide bank of input pins and raises interrupts when a programmed boolean pattern appears on them. Eight input channels each pick one pin from a 64-pin bank, which is two 32-bit ports. Eight bit slices each look at one channel and test a condition on it. The condition can be a steady level, a latched (sticky) edge, or an edge that counts only in the cycle it occurs.

Consecutive slices are ANDed into product terms. A per-slice endpoint bit closes a term, and the last slice always closes one. Each closed term drives the interrupt line at its endpoint slice's index. A global enable gates every term output. When the OR of all term outputs rises, an optional one-cycle event pulse is sent toward the processor; it can also be routed to a pin.

Sticky edge latches stay set until software pulses the re-arm input. Pins are assumed to be already synchronised to `clk`. Typical use is one configuration followed by interrupt service. Software re-arms the engine after each handled sticky match.

Top module: `pin_pattern_matcher`

## Requirements
- R1: During and right after reset, all term outputs and the event output are low.
- R2: Channel c carries the pin whose index is held in `chan_sel_i[6c+5:6c]`, and slice s reads the channel held in `slice_src_i[3s+2:3s]`.
- R3: The 3-bit condition in `slice_cond_i[3s+2:3s]` evaluates as follows: 0 is always true, 4 is true while the channel is high, 5 is true while it is low, and 6 is never true.
- R4: Code 1 latches a rising edge, code 2 a falling edge and code 3 either edge. The slice then stays true until a cycle with `rearm_i` high and no new qualifying edge. An edge in the same cycle as `rearm_i` remains latched.
- R5: Code 7 is true only in the cycle in which its channel changes value.
- R6: The output at endpoint slice e is the AND of the slices that follow the previous endpoint, up to and including e. Outputs at non-endpoint slices stay low.
- R7: The last slice is an endpoint whatever its `slice_end_i` bit says. That bit has no width in the port.
- R8: With `enable_i` low, all term outputs are low, but sticky edges still latch.
- R9: `event_o` is high for exactly one cycle when the OR of the term outputs goes from low to high, and only if `event_en_i` is high in that evaluation. It is never high otherwise.
- R10: Outputs are registered: a pin value applied before a clock edge shows on the term outputs just after that edge. Edges are detected by comparing with the previous cycle's channel value, and no edge is reported in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 64 | Synchronised pin bank (two 32-bit ports) |
| chan_sel_i | input | 48 | Pin index for each of the 8 channels, 6 bits each |
| slice_src_i | input | 24 | Channel index for each slice, 3 bits each |
| slice_cond_i | input | 24 | Condition code for each slice, 3 bits each |
| slice_end_i | input | 7 | Endpoint bits for slices 0 to 6 |
| enable_i | input | 1 | Global gate for term outputs |
| event_en_i | input | 1 | Allows the processor event pulse |
| rearm_i | input | 1 | Clears sticky edge latches |
| term_irq_o | output | 8 | Per-term interrupt, set at the endpoint slice's index |
| event_o | output | 1 | One-cycle event pulse toward the processor |

## Verification
Two things can happen in the same cycle: a software re-arm and a fresh qualifying edge on a sticky slice. The bench provokes this directly by raising the pin in the very cycle `rearm_i` is pulsed. It expects the term to stay asserted both then and in the following cycles. Random sticky runs also hit the case often, because re-arms and toggles are mixed there. A second overlap, the event pulse rising together with the first term output, is judged in every cycle against a bench model that tracks the previous OR of the terms.

// File: rtl/pin_pattern_matcher.sv
module pin_pattern_matcher #(
  parameter int NUM_PINS   = 64,
  parameter int NUM_CH     = 8,
  parameter int NUM_SLICES = 8,
  localparam int PIN_W     = $clog2(NUM_PINS),
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_PINS-1:0]     pins_i,
  input  logic [NUM_CH*PIN_W-1:0] chan_sel_i,
  input  logic [NUM_SLICES*CH_W-1:0] slice_src_i,
  input  logic [NUM_SLICES*3-1:0] slice_cond_i,
  input  logic [NUM_SLICES-2:0]   slice_end_i,
  input  logic                    enable_i,
  input  logic                    event_en_i,
  input  logic                    rearm_i,
  output logic [NUM_SLICES-1:0]   term_irq_o,
  output logic                    event_o
);

  localparam logic [2:0] C_TRUE  = 3'd0;
  localparam logic [2:0] C_RISE  = 3'd1;
  localparam logic [2:0] C_FALL  = 3'd2;
  localparam logic [2:0] C_BOTH  = 3'd3;
  localparam logic [2:0] C_HIGH  = 3'd4;
  localparam logic [2:0] C_LOW   = 3'd5;
  localparam logic [2:0] C_NEVER = 3'd6;
  localparam logic [2:0] C_PULSE = 3'd7;

  logic [NUM_CH-1:0]     ch_now, ch_prev, ch_rise, ch_fall;
  logic                  primed_q;
  logic [NUM_SLICES-1:0] end_eff, sticky_q, sticky_set, hit, term_and, term_d;
  logic                  any_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_now[c] = pins_i[chan_sel_i[c*PIN_W +: PIN_W]];
  end

  assign ch_rise = {NUM_CH{primed_q}} & ch_now & ~ch_prev;
  assign ch_fall = {NUM_CH{primed_q}} & ~ch_now & ch_prev;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    logic [CH_W-1:0] src;
    logic [2:0]      cond;
    logic            lvl, rs, fl, held;
    assign src  = slice_src_i[s*CH_W +: CH_W];
    assign cond = slice_cond_i[s*3 +: 3];
    assign lvl  = ch_now[src];
    assign rs   = ch_rise[src];
    assign fl   = ch_fall[src];
    assign sticky_set[s] = ((cond == C_RISE) && rs) ||
                           ((cond == C_FALL) && fl) ||
                           ((cond == C_BOTH) && (rs || fl));
    assign held = (sticky_q[s] && !rearm_i) || sticky_set[s];

    always_comb begin
      case (cond)
        C_TRUE:  hit[s] = 1'b1;
        C_RISE,
        C_FALL,
        C_BOTH:  hit[s] = held;
        C_HIGH:  hit[s] = lvl;
        C_LOW:   hit[s] = !lvl;
        C_NEVER: hit[s] = 1'b0;
        C_PULSE: hit[s] = rs || fl;
        default: hit[s] = 1'b0;
      endcase
    end

    if (s == NUM_SLICES - 1) begin : g_last
      assign end_eff[s] = 1'b1;
    end else begin : g_mid
      assign end_eff[s] = slice_end_i[s];
    end

    // R4: a latched edge survives every cycle without re-arm
    a_r4_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q[s] && !rearm_i) |=> sticky_q[s]);
  end

  always_comb begin
    logic run;
    run = 1'b1;
    for (int s = 0; s < NUM_SLICES; s++) begin
      run         = run & hit[s];
      term_and[s] = run;
      if (end_eff[s]) run = 1'b1;
    end
  end

  assign term_d = term_and & end_eff & {NUM_SLICES{enable_i}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_prev    <= '0;
      primed_q   <= 1'b0;
      sticky_q   <= '0;
      term_irq_o <= '0;
      any_q      <= 1'b0;
      event_o    <= 1'b0;
    end else begin
      ch_prev    <= ch_now;
      primed_q   <= 1'b1;
      sticky_q   <= (sticky_q & ~{NUM_SLICES{rearm_i}}) | sticky_set;
      term_irq_o <= term_d;
      any_q      <= |term_d;
      event_o    <= event_en_i && (|term_d) && !any_q;
    end
  end

  a_r8_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (term_irq_o == '0));

  a_r6_only_endpoints: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((term_irq_o & ~{1'b1, $past(slice_end_i)}) == '0));

  a_r9_event_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> ((|term_irq_o) && $past(event_en_i)));

  a_r9_event_single: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |=> !event_o);

  a_r7_last_endpoint: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && hit[NUM_SLICES-1] && (end_eff[NUM_SLICES-2] || term_and[NUM_SLICES-2]))
      |=> term_irq_o[NUM_SLICES-1]);

endmodule

// File: tb/pin_pattern_matcher_tb.sv
`timescale 1ns/1ps
module pin_pattern_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pins = '0;
  logic [47:0] chan_sel = '0;
  logic [23:0] src = '0;
  logic [23:0] cond = '0;
  logic [6:0]  ends = '0;
  logic        enable = 1'b0, event_en = 1'b0, rearm = 1'b0;
  logic [7:0]  term;
  logic        ev;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R1";

  bit [7:0] m_prev = '0, m_sticky = '0;
  bit       m_primed = 0, m_any = 0;

  always #2.5 clk = ~clk;

  pin_pattern_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .chan_sel_i(chan_sel),
    .slice_src_i(src), .slice_cond_i(cond), .slice_end_i(ends),
    .enable_i(enable), .event_en_i(event_en), .rearm_i(rearm),
    .term_irq_o(term), .event_o(ev));

  task automatic check(string t, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", t, got, exp, $time);
    end
  endtask

  task automatic step();
    bit [7:0] chv, r, f, hit, set, exp_t, endv;
    bit run, exp_any, exp_ev;
    for (int c = 0; c < 8; c++) chv[c] = pins[chan_sel[c*6 +: 6]];
    r = m_primed ? (chv & ~m_prev) : 8'h00;
    f = m_primed ? (~chv & m_prev) : 8'h00;
    endv = {1'b1, ends};
    for (int s = 0; s < 8; s++) begin
      int k;
      bit l, rs, fl, hold;
      k = int'(src[s*3 +: 3]);
      l = chv[k]; rs = r[k]; fl = f[k];
      case (cond[s*3 +: 3])
        3'd1: set[s] = rs;
        3'd2: set[s] = fl;
        3'd3: set[s] = rs | fl;
        default: set[s] = 0;
      endcase
      hold = (m_sticky[s] & ~rearm) | set[s];
      case (cond[s*3 +: 3])
        3'd0: hit[s] = 1;
        3'd1, 3'd2, 3'd3: hit[s] = hold;
        3'd4: hit[s] = l;
        3'd5: hit[s] = ~l;
        3'd6: hit[s] = 0;
        default: hit[s] = rs | fl;
      endcase
    end
    run = 1;
    for (int s = 0; s < 8; s++) begin
      run = run & hit[s];
      exp_t[s] = run & endv[s] & enable;
      if (endv[s]) run = 1;
    end
    exp_any = |exp_t;
    exp_ev = event_en & exp_any & ~m_any;
    @(posedge clk); #1;
    check(tag, term, exp_t);
    check("R9", {7'd0, ev}, {7'd0, exp_ev});
    m_prev = chv; m_primed = 1; m_any = exp_any;
    m_sticky = (m_sticky & ~{8{rearm}}) | set;
    @(negedge clk);
  endtask

  task automatic identity_map();
    for (int c = 0; c < 8; c++) chan_sel[c*6 +: 6] = 6'(c);
    for (int s = 0; s < 8; s++) src[s*3 +: 3] = 3'(s);
  endtask

  task automatic clear_sticky();
    rearm = 1; pins[7:0] = pins[7:0];
    cond = '0; step(); rearm = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    identity_map();
    cond = {8{3'd1}}; ends = '1; enable = 1; event_en = 1;
    pins[7:0] = 8'hFF;
    repeat (3) @(negedge clk);
    tag = "R1";
    check("R1", term, 8'h00);
    check("R1", {7'd0, ev}, 8'h00);
    rst_n = 1;
    // R10: high pins at reset release are no edge in the first cycle
    tag = "R10";
    step(); step();
    pins[7:0] = 8'h00; step();
    pins[7:0] = 8'h0F; step(); step();
    clear_sticky();

    // R2: walking one through every pin on channel 3
    tag = "R2";
    cond = {8{3'd4}}; ends = '1;
    for (int p = 0; p < 64; p++) begin
      chan_sel[3*6 +: 6] = 6'(p);
      chan_sel[5*6 +: 6] = 6'(63 - p);
      pins = 64'd1 << p;
      step();
    end
    identity_map(); pins = '0;

    // R3: every level pattern under the level-type codes
    tag = "R3";
    for (int cv = 0; cv < 4; cv++) begin
      bit [2:0] code;
      code = (cv == 0) ? 3'd0 : (cv == 1) ? 3'd4 : (cv == 2) ? 3'd5 : 3'd6;
      cond = {8{code}};
      for (int v = 0; v < 256; v++) begin pins[7:0] = 8'(v); step(); end
    end

    // R4: re-arm and a fresh edge in the same cycle
    tag = "R4";
    cond = {8{3'd1}}; ends = '1; pins[7:0] = 8'h00;
    step(); clear_sticky(); cond = {8{3'd1}};
    step();
    pins[7:0] = 8'h01; rearm = 1; step();
    rearm = 0; step(); step();
    rearm = 1; step(); rearm = 0; step();
    for (int i = 0; i < 600; i++) begin
      for (int s = 0; s < 8; s++) cond[s*3 +: 3] = 3'(1 + ($urandom % 3));
      if (i % 50 == 0) begin
        ends = 7'($urandom);
        for (int s = 0; s < 8; s++) src[s*3 +: 3] = 3'($urandom);
      end
      rearm = ($urandom % 6) == 0;
      if (($urandom % 3) == 0) pins[7:0] = pins[7:0] ^ (8'd1 << ($urandom % 8));
      step();
    end
    rearm = 0; identity_map();

    // R5: single-cycle edge code
    tag = "R5";
    cond = {8{3'd7}}; ends = '1;
    for (int i = 0; i < 300; i++) begin pins[7:0] = 8'($urandom); step(); end
    pins[7:0] = 8'h00; step(); step();

    // R6: random chaining of mixed conditions
    tag = "R6";
    for (int i = 0; i < 1500; i++) begin
      if (i % 8 == 0) begin
        ends = 7'($urandom);
        for (int s = 0; s < 8; s++) begin
          cond[s*3 +: 3] = 3'($urandom);
          src[s*3 +: 3] = 3'($urandom);
        end
        for (int c = 0; c < 8; c++) chan_sel[c*6 +: 6] = 6'($urandom);
      end
      rearm = ($urandom % 5) == 0;
      event_en = ($urandom % 4) != 0;
      pins = {$urandom, $urandom};
      step();
    end
    rearm = 0; event_en = 1; identity_map();

    // R7: no endpoint bits set, slice 7 still closes the full term
    tag = "R7";
    ends = '0; cond = {8{3'd4}};
    for (int v = 0; v < 256; v++) begin pins[7:0] = 8'(v); step(); end

    // R8: gate off while sticky edges latch, then gate on
    tag = "R8";
    ends = '1; clear_sticky(); cond = {8{3'd3}}; pins[7:0] = 8'h00; step();
    enable = 0;
    pins[7:0] = 8'hA5; step(); pins[7:0] = 8'h00; step(); step();
    enable = 1; step(); step();

    // R9: event gating and repeated rises
    tag = "R9";
    cond = {8{3'd4}};
    for (int i = 0; i < 400; i++) begin
      event_en = $urandom % 2;
      enable = ($urandom % 8) != 0;
      pins[7:0] = (($urandom % 3) == 0) ? 8'($urandom) : 8'h00;
      step();
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule